// File: doc/BRIEF.md
# Reset Combination Legality Monitor

This block watches the reset inputs of a four-core cluster and reports, every clock, what they are doing. Each core has four active-low reset inputs: power-on, core, vector/floating-point (SIMD) and core-side debug. The cluster also has two shared active-low resets, one for the debug bus and one for the L2, interrupt and timer logic. From these inputs the monitor derives a map of the logic domains that are held in reset. It also names the input vector as one of a fixed set of permitted reset combinations, or as unclassified.

The monitor also checks two usage rules against per-core status inputs. The L2 reset must not be asserted while any core is marked active. The debug-bus reset must not be asserted while any core is marked as being debugged. A breach of either rule, or an unclassified vector, sets a sticky error flag, which stays set until software pulses a clear input. All outputs are registered on the monitor clock, one cycle behind the inputs. The widths of the reset pulses are not checked.

Top module: `rst_combo_monitor`

## Requirements
- R1: Each core's domain map, registered one cycle after the inputs. A low power-on reset marks the core, SIMD and debug domains of that core held. A low core reset marks the core and SIMD domains held. A low SIMD reset marks only the SIMD domain held. A low core-debug reset marks only the debug domain held.
- R2: A low debug-bus reset sets held_dbus, and a low L2 reset sets held_l2. Both are registered one cycle after the inputs.
- R3: When every reset input is high, the next combo_code is 0 (run) and no held bit is set.
- R4: Power-up combinations. In each of these, a selected core has its power-on reset low, and its other three resets are don't-care. Every other core has all four of its resets high.
  - Code 1: all cores selected, debug bus low, L2 low.
  - Code 2: one or more cores selected, debug bus low, L2 high.
  - Code 3: all cores selected, debug bus high, L2 low.
  - Code 4: one or more cores selected, debug bus high, L2 high.
- R5: Soft combinations. In each of these, a selected core has its core reset low, its power-on and core-debug resets high, and its SIMD reset don't-care.
  - Code 5: all cores selected, both shared resets high.
  - Code 6: all cores selected, debug bus high, L2 low.
  - Code 7: one or more cores selected, the remaining cores idle, both shared resets high.
- R6: Combinations that only touch the SIMD and debug domains. In each of these, a selected core has only the named resets low, and every core not selected has all four of its resets high.
  - Code 8: SIMD only, both shared resets high.
  - Code 9: every core's core-debug reset low, debug bus low, L2 high.
  - Code 10: core-debug only, both shared resets high.
  - Code 11: no core reset low, debug bus low, L2 high.
  - Code 12: SIMD only, debug bus low, L2 high.
  - Code 13: SIMD and core-debug together, both shared resets high.
- R7: When more than one code matches, the lowest code wins. A vector that matches no code gives code 15 and sets err_flag in the same cycle as the code.
- R8: A low L2 reset while any bit of core_active is 1 sets err_flag on the next cycle, whatever the code.
- R9: A low debug-bus reset while any bit of core_debugged is 1 sets err_flag on the next cycle.
- R10: err_flag holds its value until err_clr is high in a cycle with no error source. If a new error source is present in the same cycle as err_clr, err_flag stays set.
- R11: While rst_n is low, all held bits, combo_code and err_flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Monitor reset, active low |
| por_n | input | NUM_CORES | Per-core power-on reset, active low |
| core_n | input | NUM_CORES | Per-core core reset, active low |
| simd_n | input | NUM_CORES | Per-core SIMD/FP reset, active low |
| dbgc_n | input | NUM_CORES | Per-core debug-logic reset, active low |
| dbus_n | input | 1 | Shared debug-bus reset, active low |
| l2_n | input | 1 | Shared L2/interrupt/timer reset, active low |
| core_active | input | NUM_CORES | Core is active |
| core_debugged | input | NUM_CORES | Core is being debugged |
| err_clr | input | 1 | Clears the sticky error flag |
| held_core | output | NUM_CORES | Core domain held in reset |
| held_simd | output | NUM_CORES | SIMD domain held in reset |
| held_dbg | output | NUM_CORES | Debug domain held in reset |
| held_dbus | output | 1 | Debug-bus domain held in reset |
| held_l2 | output | 1 | L2 domain held in reset |
| combo_code | output | 4 | Classified combination |
| err_flag | output | 1 | Sticky error flag |

## Verification
The hardest cases to reach are the ones where two rules compete. In some, a vector fits more than one code, or a legal combination still carries a usage error. In others, a clear arrives in the same cycle as a fresh error. The directed tasks build each of these on purpose, and check the result at the next falling edge:
- All core-debug resets low with the debug bus high. This must resolve to code 10, not code 9.
- A full power-up with one core marked active. The code stays 1, and the error is still raised.
- A clear pulsed together with an unclassified vector. The flag must stay set.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

    typedef enum logic [3:0] {
        CODE_RUN          = 4'd0,
        CODE_PWR_ALL      = 4'd1,
        CODE_PWR_SEL_DBUS = 4'd2,
        CODE_PWR_ALL_DBON = 4'd3,
        CODE_PWR_SEL      = 4'd4,
        CODE_SOFT_ALL     = 4'd5,
        CODE_SOFT_ALL_L2  = 4'd6,
        CODE_SOFT_SEL     = 4'd7,
        CODE_SIMD_SEL     = 4'd8,
        CODE_DBG_ALL      = 4'd9,
        CODE_DBG_SEL      = 4'd10,
        CODE_DBUS         = 4'd11,
        CODE_SIMD_DBUS    = 4'd12,
        CODE_SIMD_DBG     = 4'd13,
        CODE_UNCLASS      = 4'd15
    } combo_e;

    typedef enum logic [2:0] {
        K_IDLE,
        K_PWR,
        K_SOFT,
        K_SIMD,
        K_DBG,
        K_SIMD_DBG,
        K_BAD
    } core_kind_e;

endpackage

// File: rtl/rcm_core_decode.sv
module rcm_core_decode
    import rcm_pkg::*;
(
    input  logic       por_n,
    input  logic       core_n,
    input  logic       simd_n,
    input  logic       dbgc_n,
    output core_kind_e kind,
    output logic       hold_core,
    output logic       hold_simd,
    output logic       hold_dbg
);

    always_comb begin
        hold_core = !por_n || !core_n;
        hold_simd = !por_n || !core_n || !simd_n;
        hold_dbg  = !por_n || !dbgc_n;

        if (!por_n) begin
            kind = K_PWR;
        end else if (!core_n) begin
            kind = dbgc_n ? K_SOFT : K_BAD;
        end else if (!simd_n && !dbgc_n) begin
            kind = K_SIMD_DBG;
        end else if (!simd_n) begin
            kind = K_SIMD;
        end else if (!dbgc_n) begin
            kind = K_DBG;
        end else begin
            kind = K_IDLE;
        end
    end

endmodule

// File: rtl/rcm_classify.sv
module rcm_classify
    import rcm_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  core_kind_e kind [NUM_CORES],
    input  logic       dbus_n,
    input  logic       l2_n,
    output combo_e     code
);

    localparam logic [NUM_CORES-1:0] ALL_ONES = {NUM_CORES{1'b1}};

    logic [NUM_CORES-1:0] m_idle, m_pwr, m_soft, m_simd, m_dbg, m_sdbg;

    function automatic logic sel_only(input logic [NUM_CORES-1:0] m,
                                      input logic [NUM_CORES-1:0] idle);
        return (|m) && ((m | idle) == ALL_ONES);
    endfunction

    always_comb begin
        for (int i = 0; i < NUM_CORES; i++) begin
            m_idle[i] = (kind[i] == K_IDLE);
            m_pwr[i]  = (kind[i] == K_PWR);
            m_soft[i] = (kind[i] == K_SOFT);
            m_simd[i] = (kind[i] == K_SIMD);
            m_dbg[i]  = (kind[i] == K_DBG);
            m_sdbg[i] = (kind[i] == K_SIMD_DBG);
        end

        code = CODE_UNCLASS;
        if ((m_idle == ALL_ONES) && dbus_n && l2_n)
            code = CODE_RUN;
        else if ((m_pwr == ALL_ONES) && !dbus_n && !l2_n)
            code = CODE_PWR_ALL;
        else if (sel_only(m_pwr, m_idle) && !dbus_n && l2_n)
            code = CODE_PWR_SEL_DBUS;
        else if ((m_pwr == ALL_ONES) && dbus_n && !l2_n)
            code = CODE_PWR_ALL_DBON;
        else if (sel_only(m_pwr, m_idle) && dbus_n && l2_n)
            code = CODE_PWR_SEL;
        else if ((m_soft == ALL_ONES) && dbus_n && l2_n)
            code = CODE_SOFT_ALL;
        else if ((m_soft == ALL_ONES) && dbus_n && !l2_n)
            code = CODE_SOFT_ALL_L2;
        else if (sel_only(m_soft, m_idle) && dbus_n && l2_n)
            code = CODE_SOFT_SEL;
        else if (sel_only(m_simd, m_idle) && dbus_n && l2_n)
            code = CODE_SIMD_SEL;
        else if ((m_dbg == ALL_ONES) && !dbus_n && l2_n)
            code = CODE_DBG_ALL;
        else if (sel_only(m_dbg, m_idle) && dbus_n && l2_n)
            code = CODE_DBG_SEL;
        else if ((m_idle == ALL_ONES) && !dbus_n && l2_n)
            code = CODE_DBUS;
        else if (sel_only(m_simd, m_idle) && !dbus_n && l2_n)
            code = CODE_SIMD_DBUS;
        else if (sel_only(m_sdbg, m_idle) && dbus_n && l2_n)
            code = CODE_SIMD_DBG;
    end

endmodule

// File: rtl/rst_combo_monitor.sv
module rst_combo_monitor
    import rcm_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] por_n,
    input  logic [NUM_CORES-1:0] core_n,
    input  logic [NUM_CORES-1:0] simd_n,
    input  logic [NUM_CORES-1:0] dbgc_n,
    input  logic                 dbus_n,
    input  logic                 l2_n,
    input  logic [NUM_CORES-1:0] core_active,
    input  logic [NUM_CORES-1:0] core_debugged,
    input  logic                 err_clr,
    output logic [NUM_CORES-1:0] held_core,
    output logic [NUM_CORES-1:0] held_simd,
    output logic [NUM_CORES-1:0] held_dbg,
    output logic                 held_dbus,
    output logic                 held_l2,
    output logic [3:0]           combo_code,
    output logic                 err_flag
);

    typedef struct packed {
        logic [NUM_CORES-1:0] held_core;
        logic [NUM_CORES-1:0] held_simd;
        logic [NUM_CORES-1:0] held_dbg;
        logic                 held_dbus;
        logic                 held_l2;
        combo_e               code;
        logic                 err;
    } mon_state_t;

    mon_state_t s_d, s_q;

    core_kind_e           kind_c [NUM_CORES];
    logic [NUM_CORES-1:0] hc_c, hs_c, hd_c;
    combo_e               code_c;
    logic                 usage_err_c;
    logic                 err_src_c;

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        rcm_core_decode i_dec (
            .por_n     (por_n[g]),
            .core_n    (core_n[g]),
            .simd_n    (simd_n[g]),
            .dbgc_n    (dbgc_n[g]),
            .kind      (kind_c[g]),
            .hold_core (hc_c[g]),
            .hold_simd (hs_c[g]),
            .hold_dbg  (hd_c[g])
        );
    end

    rcm_classify #(.NUM_CORES(NUM_CORES)) i_cls (
        .kind   (kind_c),
        .dbus_n (dbus_n),
        .l2_n   (l2_n),
        .code   (code_c)
    );

    always_comb begin
        usage_err_c = (!l2_n && (|core_active)) || (!dbus_n && (|core_debugged));
        err_src_c   = (code_c == CODE_UNCLASS) || usage_err_c;

        s_d           = s_q;
        s_d.held_core = hc_c;
        s_d.held_simd = hs_c;
        s_d.held_dbg  = hd_c;
        s_d.held_dbus = !dbus_n;
        s_d.held_l2   = !l2_n;
        s_d.code      = code_c;
        if (err_src_c)
            s_d.err = 1'b1;
        else if (err_clr)
            s_d.err = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{default: '0, code: CODE_RUN};
        end else begin
            s_q <= s_d;
        end
    end

    assign held_core  = s_q.held_core;
    assign held_simd  = s_q.held_simd;
    assign held_dbg   = s_q.held_dbg;
    assign held_dbus  = s_q.held_dbus;
    assign held_l2    = s_q.held_l2;
    assign combo_code = s_q.code;
    assign err_flag   = s_q.err;

    // R3
    run_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&{por_n, core_n, simd_n, dbgc_n, dbus_n, l2_n}) |=>
        (combo_code == 4'd0 && held_core == '0 && held_simd == '0 &&
         held_dbg == '0 && !held_dbus && !held_l2));

    // R7
    unclass_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_c == CODE_UNCLASS) |=> (err_flag && combo_code == 4'd15));

    // R8
    l2_usage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!l2_n && (|core_active)) |=> err_flag);

    // R9
    dbus_usage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbus_n && (|core_debugged)) |=> err_flag);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);

    // R10
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !err_src_c) |=> !err_flag);

    // R1
    por_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (por_n != {NUM_CORES{1'b1}}) |=>
        ((held_core & held_simd & held_dbg & ~$past(por_n)) == ~$past(por_n)));

endmodule

// File: tb/test_rst_combo_monitor.sv
module test_rst_combo_monitor;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] por_n = '1, core_n = '1, simd_n = '1, dbgc_n = '1;
    logic         dbus_n = 1'b1, l2_n = 1'b1;
    logic [N-1:0] core_active = '0, core_debugged = '0;
    logic         err_clr = 1'b0;
    logic [N-1:0] held_core, held_simd, held_dbg;
    logic         held_dbus, held_l2, err_flag;
    logic [3:0]   combo_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rst_combo_monitor #(.NUM_CORES(N)) i_rst_combo_monitor (
        .clk(clk), .rst_n(rst_n),
        .por_n(por_n), .core_n(core_n), .simd_n(simd_n), .dbgc_n(dbgc_n),
        .dbus_n(dbus_n), .l2_n(l2_n),
        .core_active(core_active), .core_debugged(core_debugged),
        .err_clr(err_clr),
        .held_core(held_core), .held_simd(held_simd), .held_dbg(held_dbg),
        .held_dbus(held_dbus), .held_l2(held_l2),
        .combo_code(combo_code), .err_flag(err_flag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // drive inputs just after a falling edge, then wait for the next falling edge
    task automatic apply(input logic [N-1:0] p, c, s, d, input logic b, l);
        por_n = p; core_n = c; simd_n = s; dbgc_n = d; dbus_n = b; l2_n = l;
        @(negedge clk);
    endtask

    function automatic int held_vec();
        return int'({held_core, held_simd, held_dbg, held_dbus, held_l2});
    endfunction

    task automatic clear_err();
        core_active = '0; core_debugged = '0;
        err_clr = 1'b1;
        apply('1, '1, '1, '1, 1'b1, 1'b1);
        err_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11", "code in reset", int'(combo_code), 0);
        chk("R11", "held in reset", held_vec(), 0);
        chk("R11", "err in reset", int'(err_flag), 0);
        rst_n = 1'b1;
        @(negedge clk);
        apply('1, '1, '1, '1, 1'b1, 1'b1);
        chk("R3", "run code", int'(combo_code), 0);
        chk("R3", "run held", held_vec(), 0);
        chk("R3", "run err", int'(err_flag), 0);
    endtask

    task automatic t_powerup();
        clear_err();
        apply(4'b0000, '1, '1, '1, 1'b0, 1'b0);
        chk("R4", "full powerup code", int'(combo_code), 1);
        chk("R1", "full powerup held", held_vec(), int'({4'hF, 4'hF, 4'hF, 1'b1, 1'b1}));
        chk("R2", "full powerup err", int'(err_flag), 0);
        apply(4'b1011, 4'b1011, '1, '1, 1'b0, 1'b1);
        chk("R4", "single powerup w/ dbus code", int'(combo_code), 2);
        chk("R1", "single powerup held", held_vec(), int'({4'h4, 4'h4, 4'h4, 1'b1, 1'b0}));
        apply(4'b0000, '1, '1, '1, 1'b1, 1'b0);
        chk("R4", "all powerup dbus on code", int'(combo_code), 3);
        apply(4'b1101, '1, 4'b1101, '1, 1'b1, 1'b1);
        chk("R4", "single powerup code", int'(combo_code), 4);
        chk("R4", "no err", int'(err_flag), 0);
    endtask

    task automatic t_soft();
        clear_err();
        apply('1, 4'b0000, 4'b1010, '1, 1'b1, 1'b1);
        chk("R5", "all soft code", int'(combo_code), 5);
        chk("R1", "all soft held", held_vec(), int'({4'hF, 4'hF, 4'h0, 1'b0, 1'b0}));
        apply('1, 4'b0000, '1, '1, 1'b1, 1'b0);
        chk("R5", "all soft + l2 code", int'(combo_code), 6);
        chk("R8", "l2 low, nobody active, no err", int'(err_flag), 0);
        apply('1, 4'b0111, '1, '1, 1'b1, 1'b1);
        chk("R5", "single soft code", int'(combo_code), 7);
        chk("R1", "single soft held", held_vec(), int'({4'h8, 4'h8, 4'h0, 1'b0, 1'b0}));
        apply('1, 4'b0111, '1, 4'b0111, 1'b1, 1'b1);
        chk("R7", "soft with debug low code", int'(combo_code), 15);
        chk("R7", "soft with debug low err", int'(err_flag), 1);
    endtask

    task automatic t_simd_dbg();
        clear_err();
        apply('1, '1, 4'b1110, '1, 1'b1, 1'b1);
        chk("R6", "simd code", int'(combo_code), 8);
        chk("R1", "simd held", held_vec(), int'({4'h0, 4'h1, 4'h0, 1'b0, 1'b0}));
        apply('1, '1, '1, 4'b0000, 1'b0, 1'b1);
        chk("R6", "all debug code", int'(combo_code), 9);
        chk("R2", "all debug held", held_vec(), int'({4'h0, 4'h0, 4'hF, 1'b1, 1'b0}));
        apply('1, '1, '1, 4'b0000, 1'b1, 1'b1);
        chk("R7", "priority: all debug, bus high", int'(combo_code), 10);
        apply('1, '1, '1, 4'b1101, 1'b1, 1'b1);
        chk("R6", "single debug code", int'(combo_code), 10);
        apply('1, '1, '1, '1, 1'b0, 1'b1);
        chk("R6", "dbus only code", int'(combo_code), 11);
        apply('1, '1, 4'b1011, '1, 1'b0, 1'b1);
        chk("R6", "simd + dbus code", int'(combo_code), 12);
        apply('1, '1, 4'b0111, 4'b0111, 1'b1, 1'b1);
        chk("R6", "simd + debug code", int'(combo_code), 13);
        chk("R1", "simd + debug held", held_vec(), int'({4'h0, 4'h8, 4'h8, 1'b0, 1'b0}));
        chk("R6", "no err", int'(err_flag), 0);
    endtask

    task automatic t_unclass();
        clear_err();
        apply(4'b1110, 4'b1101, '1, '1, 1'b1, 1'b1);
        chk("R7", "mixed code", int'(combo_code), 15);
        chk("R7", "mixed err", int'(err_flag), 1);
    endtask

    task automatic t_usage();
        clear_err();
        core_active = 4'b0001;
        apply(4'b0000, '1, '1, '1, 1'b0, 1'b0);
        chk("R8", "l2 with active code", int'(combo_code), 1);
        chk("R8", "l2 with active err", int'(err_flag), 1);
        clear_err();
        core_debugged = 4'b0010;
        apply('1, '1, '1, '1, 1'b1, 1'b1);
        chk("R9", "debugged, bus high err", int'(err_flag), 0);
        apply('1, '1, '1, '1, 1'b0, 1'b1);
        chk("R9", "debugged, bus low err", int'(err_flag), 1);
        core_debugged = '0;
    endtask

    task automatic t_sticky();
        clear_err();
        apply(4'b1110, 4'b1101, '1, '1, 1'b1, 1'b1);
        apply('1, '1, '1, '1, 1'b1, 1'b1);
        chk("R10", "sticky after legal vector", int'(err_flag), 1);
        apply('1, '1, '1, '1, 1'b1, 1'b1);
        chk("R10", "still sticky", int'(err_flag), 1);
        err_clr = 1'b1;
        apply('1, '1, '1, '1, 1'b1, 1'b1);
        err_clr = 1'b0;
        chk("R10", "cleared", int'(err_flag), 0);
        err_clr = 1'b1;
        apply(4'b1110, 4'b1101, '1, '1, 1'b1, 1'b1);
        err_clr = 1'b0;
        chk("R10", "set wins over clear", int'(err_flag), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_powerup();
        t_soft();
        t_simd_dbg();
        t_unclass();
        t_usage();
        t_sticky();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule